// File: doc/BRIEF.md
# Reorder-Buffer Entry Sharing Grouper

This block looks at a group of decoded instruction lanes that arrive side by side in one cycle and decides which neighbouring lanes can be folded into one reorder-buffer entry. A lane qualifies for sharing when it is a complete, clean instruction. That means it is valid, it is not part of a fused pair, it is the final micro-op of its instruction, it raised no exception, and the decoder marked it as a sharing candidate. Adjacent qualifying lanes form a run, and the whole run occupies a single entry.

For every lane the block reports three things: whether that lane must request a new entry, how many instructions the entry holds, and a lane mask naming every lane that sits in the same entry. The allocator downstream uses these outputs to hand out entry indices. The whole decision is combinational, so the outputs follow the inputs in the same cycle.

Top module: `rob_share_grouper`

## Requirements
- R1: A lane counts as shareable only when all of these hold: `lane_valid` is 1, `fuse_flag` is 0 (the fusion indicator taken from bit 2 of the lane's commit type), `last_uop` is 1, every bit of the lane's `exc_vec` field is 0, and `share_hint` is 1. If any one of these conditions fails, the lane is not shareable.
- R2: `need_entry[n]` is 1 in two cases. The first is when lane n is not shareable. The second is when lane n is the highest-numbered lane of its run of consecutive shareable lanes. In every other case it is 0.
- R3: `grp_size[n]` is 1 for a lane that is not shareable. For a shareable lane it equals the number of lanes in that lane's run.
- R4: `grp_mask[n]` is LANES bits wide, and bit k stands for lane k. A lane that is not shareable has only bit n set. A shareable lane has exactly the bits of the lanes in its run set.
- R5: Take the shareable pattern (lane5..lane0) 1,0,0,1,1,0. For it, `need_entry` is 1,1,1,1,0,1 and the sizes are 1,1,1,2,2,1. Lanes 1 and 2 both carry mask 000110, and every other lane carries only its own bit.
- R6: An invalid lane reports need 1, size 1 and a mask with only its own bit set.
- R7: All outputs are a combinational function of the current inputs. There is no register, so the outputs are correct in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lane_valid | input | LANES | Lane holds a decoded instruction |
| fuse_flag | input | LANES | Fusion indicator per lane |
| last_uop | input | LANES | Lane is the final micro-op of its instruction |
| exc_vec | input | LANES*EXC_W | Exception flags, EXC_W bits per lane |
| share_hint | input | LANES | Decoder marks the lane as a sharing candidate |
| need_entry | output | LANES | Lane must request a new entry |
| grp_size | output | LANES*SIZE_W | Instructions in the lane's entry |
| grp_mask | output | LANES*LANES | Lanes sharing the lane's entry |

## Verification
The main function is tried with several kinds of input pattern:
- All lanes shareable, which gives one six-wide run.
- Alternating patterns, which give runs of length one.
- The fixed mixed pattern of R5.
- Runs touching lane 0 and runs touching the top lane, which separate errors at the scan boundaries.

Each disqualifier of R1 is then flipped alone inside an otherwise shareable group. This shows that every condition can split a run, and it tells a missing qualifier term apart from a run-scan fault. Invalid-lane patterns confirm that the outputs stay well defined. A long series of biased random groups then compares every lane's need, size and mask against an independent run model.

// File: rtl/rob_share_pkg.sv
package rob_share_pkg;
  parameter int unsigned RSG_LANES_DEF = 6;
  parameter int unsigned RSG_EXC_W_DEF = 8;

  function automatic int unsigned rsg_bits(input int unsigned v);
    int unsigned w;
    w = 1;
    while ((1 << w) <= v) w++;
    return w;
  endfunction
endpackage

// File: rtl/rsg_lane_qual.sv
module rsg_lane_qual #(
  parameter int unsigned EXC_W = 8
) (
  input  logic             valid_i,
  input  logic             fuse_i,
  input  logic             last_i,
  input  logic [EXC_W-1:0] exc_i,
  input  logic             hint_i,
  output logic             share_o
);
  logic clean;

  always_comb begin
    clean   = (exc_i == '0);
    share_o = valid_i & ~fuse_i & last_i & clean & hint_i;
  end
endmodule

// File: rtl/rsg_run_span.sv
module rsg_run_span #(
  parameter int unsigned LANES = 6,
  parameter int unsigned IDX_W = 3
) (
  input  logic [LANES-1:0]            share_i,
  output logic [LANES-1:0][IDX_W-1:0] lo_o,
  output logic [LANES-1:0][IDX_W-1:0] hi_o
);
  for (genvar n = 0; n < LANES; n++) begin : g_span
    always_comb begin
      logic up_open;
      logic dn_open;
      int   k;
      lo_o[n] = IDX_W'(n);
      hi_o[n] = IDX_W'(n);
      up_open = 1'b1;
      dn_open = 1'b1;
      for (int j = 0; j < LANES; j++) begin
        if (j > n) begin
          if (up_open && share_i[j]) hi_o[n] = IDX_W'(j);
          else up_open = 1'b0;
        end
      end
      for (int j = 0; j < LANES; j++) begin
        k = n - 1 - j;
        if (k >= 0) begin
          if (dn_open && share_i[k]) lo_o[n] = IDX_W'(k);
          else dn_open = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rsg_lane_out.sv
module rsg_lane_out #(
  parameter int unsigned LANES  = 6,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned SELF   = 0
) (
  input  logic              share_i,
  input  logic              next_share_i,
  input  logic [IDX_W-1:0]  lo_i,
  input  logic [IDX_W-1:0]  hi_i,
  output logic              need_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [LANES-1:0]  mask_o
);
  logic top_of_run;

  always_comb begin
    top_of_run = (SELF == LANES - 1) ? 1'b1 : ~next_share_i;
    need_o     = ~share_i | top_of_run;
    if (share_i) size_o = SIZE_W'(int'(hi_i) - int'(lo_i) + 1);
    else         size_o = SIZE_W'(1);
    for (int k = 0; k < LANES; k++) begin
      if (share_i) mask_o[k] = (k >= int'(lo_i)) && (k <= int'(hi_i));
      else         mask_o[k] = (k == SELF);
    end
  end
endmodule

// File: rtl/rob_share_grouper.sv
module rob_share_grouper
  import rob_share_pkg::*;
#(
  parameter int unsigned LANES  = RSG_LANES_DEF,
  parameter int unsigned EXC_W  = RSG_EXC_W_DEF,
  localparam int unsigned IDX_W  = rsg_bits(LANES - 1),
  localparam int unsigned SIZE_W = rsg_bits(LANES)
) (
  input  logic [LANES-1:0]             lane_valid,
  input  logic [LANES-1:0]             fuse_flag,
  input  logic [LANES-1:0]             last_uop,
  input  logic [LANES-1:0][EXC_W-1:0]  exc_vec,
  input  logic [LANES-1:0]             share_hint,
  output logic [LANES-1:0]             need_entry,
  output logic [LANES-1:0][SIZE_W-1:0] grp_size,
  output logic [LANES-1:0][LANES-1:0]  grp_mask
);
  logic [LANES-1:0]            share;
  logic [LANES:0]              share_ext;
  logic [LANES-1:0][IDX_W-1:0] run_lo;
  logic [LANES-1:0][IDX_W-1:0] run_hi;

  for (genvar n = 0; n < LANES; n++) begin : g_qual
    rsg_lane_qual #(.EXC_W(EXC_W)) qual_i (
      .valid_i (lane_valid[n]),
      .fuse_i  (fuse_flag[n]),
      .last_i  (last_uop[n]),
      .exc_i   (exc_vec[n]),
      .hint_i  (share_hint[n]),
      .share_o (share[n])
    );
  end

  assign share_ext = {1'b0, share};

  rsg_run_span #(.LANES(LANES), .IDX_W(IDX_W)) span_i (
    .share_i (share),
    .lo_o    (run_lo),
    .hi_o    (run_hi)
  );

  for (genvar n = 0; n < LANES; n++) begin : g_out
    rsg_lane_out #(
      .LANES(LANES), .IDX_W(IDX_W), .SIZE_W(SIZE_W), .SELF(n)
    ) out_i (
      .share_i      (share[n]),
      .next_share_i (share_ext[n+1]),
      .lo_i         (run_lo[n]),
      .hi_i         (run_hi[n]),
      .need_o       (need_entry[n]),
      .size_o       (grp_size[n]),
      .mask_o       (grp_mask[n])
    );
  end
endmodule

// File: rtl/rob_share_grouper_chk.sv
module rob_share_grouper_chk #(
  parameter int unsigned LANES  = 6,
  parameter int unsigned SIZE_W = 3
) (
  input logic [LANES-1:0]             need_entry,
  input logic [LANES-1:0][SIZE_W-1:0] grp_size,
  input logic [LANES-1:0][LANES-1:0]  grp_mask
);
  always_comb begin
    if (!$isunknown({need_entry, grp_size, grp_mask})) begin
      // R2
      top_need_chk: assert (need_entry[LANES-1]);
      for (int n = 0; n < LANES; n++) begin
        // R4
        self_bit_chk: assert (grp_mask[n][n]);
        // R3
        size_pop_chk: assert (int'(grp_size[n]) == $countones(grp_mask[n]));
        // R2
        one_need_chk: assert ($countones(grp_mask[n] & need_entry) == 1);
        for (int k = 0; k < LANES; k++) begin
          // R4
          if (grp_mask[n][k]) begin
            mask_sym_chk: assert (grp_mask[k] == grp_mask[n]);
          end
        end
      end
    end
  end
endmodule

bind rob_share_grouper rob_share_grouper_chk #(
  .LANES(LANES), .SIZE_W(SIZE_W)
) chk_i (
  .need_entry (need_entry),
  .grp_size   (grp_size),
  .grp_mask   (grp_mask)
);

// File: tb/rob_share_grouper_tb_top.sv
`timescale 1ns/1ps
module rob_share_grouper_tb_top;
  localparam int L  = 6;
  localparam int EW = 8;
  localparam int SW = 3;

  typedef struct {
    logic [L-1:0]         need;
    logic [L-1:0][SW-1:0] size;
    logic [L-1:0][L-1:0]  mask;
    string                tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [L-1:0]          lane_valid = '0;
  logic [L-1:0]          fuse_flag  = '0;
  logic [L-1:0]          last_uop   = '0;
  logic [L-1:0][EW-1:0]  exc_vec    = '0;
  logic [L-1:0]          share_hint = '0;
  logic [L-1:0]          need_entry;
  logic [L-1:0][SW-1:0]  grp_size;
  logic [L-1:0][L-1:0]   grp_mask;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;
  exp_t q[$];

  rob_share_grouper #(.LANES(L), .EXC_W(EW)) dut_i (
    .lane_valid (lane_valid),
    .fuse_flag  (fuse_flag),
    .last_uop   (last_uop),
    .exc_vec    (exc_vec),
    .share_hint (share_hint),
    .need_entry (need_entry),
    .grp_size   (grp_size),
    .grp_mask   (grp_mask)
  );

  function automatic exp_t model(input logic [L-1:0] v, f, la, h,
                                 input logic [L-1:0][EW-1:0] e, input string tag);
    exp_t r;
    logic [L-1:0] c;
    int start;
    logic [L-1:0] m;
    r.tag = tag;
    for (int i = 0; i < L; i++)
      c[i] = v[i] && !f[i] && la[i] && (e[i] == 0) && h[i];
    start = 0;
    for (int i = 0; i < L; i++) begin
      r.need[i] = 1'b1;
      r.size[i] = SW'(1);
      r.mask[i] = L'(1) << i;
    end
    for (int i = 0; i < L; i++) begin
      if (c[i]) begin
        if (i == 0 || !c[i-1]) start = i;
        if (i == L - 1 || !c[i+1]) begin
          m = '0;
          for (int k = start; k <= i; k++) m[k] = 1'b1;
          for (int k = start; k <= i; k++) begin
            r.need[k] = (k == i);
            r.size[k] = SW'(i - start + 1);
            r.mask[k] = m;
          end
        end
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [L-1:0] v, f, la, h,
                       input logic [L-1:0][EW-1:0] e, input string tag);
    @(posedge clk);
    #1;
    lane_valid = v; fuse_flag = f; last_uop = la; share_hint = h; exc_vec = e;
    q.push_back(model(v, f, la, h, e, tag));
  endtask

  // all lanes clean; shareable lanes given by pattern s
  task automatic drive_pat(input logic [L-1:0] s, input string tag);
    drive('1, '0, '1, s, '0, tag);
  endtask

  // R7: monitor samples at the falling edge of the cycle the inputs were applied
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if (need_entry !== x.need) begin
        errors++;
        $display("FAIL R2 %s need actual=%b expected=%b", x.tag, need_entry, x.need);
      end
      checks++;
      if (grp_size !== x.size) begin
        errors++;
        $display("FAIL R3 %s size actual=%h expected=%h", x.tag, grp_size, x.size);
      end
      checks++;
      if (grp_mask !== x.mask) begin
        errors++;
        $display("FAIL R4 %s mask actual=%h expected=%h", x.tag, grp_mask, x.mask);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d cycles expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] v, f, la, h;
    logic [L-1:0][EW-1:0] e;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: idle, all-zero inputs (R6)
    drive('0, '0, '0, '0, '0, "R6 idle");
    drive_pat(6'b100110, "R5 example");
    drive_pat(6'b111111, "R3 full run");
    drive_pat(6'b010101, "R2 alternating");
    drive_pat(6'b101010, "R2 alternating hi");
    drive_pat(6'b000011, "R4 run at lane0");
    drive_pat(6'b110000, "R4 run at top");
    drive_pat(6'b011110, "R3 inner run");
    drive_pat(6'b000000, "R2 none shareable");
    // R1: flip one disqualifier on lane 2 of a full run
    drive(6'b111011, '0, '1, '1, '0, "R1 invalid lane2");
    drive('1, 6'b000100, '1, '1, '0, "R1 fused lane2");
    drive('1, '0, 6'b111011, '1, '0, "R1 not last lane2");
    e = '0; e[2] = 8'h80;
    drive('1, '0, '1, '1, e, "R1 exc hi bit lane2");
    e = '0; e[2] = 8'h01;
    drive('1, '0, '1, '1, e, "R1 exc lo bit lane2");
    drive('1, '0, '1, 6'b111011, '0, "R1 no hint lane2");
    // R6: invalid lanes with otherwise shareable attributes
    drive(6'b000000, '0, '1, '1, '0, "R6 all invalid");
    drive(6'b011110, '0, '1, '1, '0, "R6 edge invalid");
    for (int t = 0; t < 400; t++) begin
      v = '1; f = '0; la = '1; h = '1; e = '0;
      for (int i = 0; i < L; i++) begin
        case ($urandom_range(0, 7))
          0: v[i] = 1'b0;
          1: f[i] = 1'b1;
          2: la[i] = 1'b0;
          3: e[i] = EW'(1) << $urandom_range(0, EW - 1);
          4: h[i] = 1'b0;
          default: ;
        endcase
      end
      drive(v, f, la, h, e, "R1 random");
    end
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule